// File: doc/BRIEF.md
# Fractional-Delay Lagrange Deskew Filter

This block removes a sub-sample timing skew from one complex (I/Q) sample stream. An upstream stage aligns the stream to the nearest whole sample; what remains is a fractional offset, for example from converter skew or a sampling-phase error. The block re-samples the stream at that offset by Lagrange polynomial interpolation of order 2l over the 2l+1 samples around each centre sample.

The offset is loaded as a signed fixed-point value. When it is written, a small sequential engine computes the 2l+1 tap weights c_i = prod over j != i of (s0 - j)/(i - j), with every constant denominator replaced by a precomputed reciprocal. The new weights then replace the active set in one cycle. The interpolating FIR runs on I and Q with one shared set of weights, and its results are rounded and saturated back to the input width. The half-width l is a build-time parameter (default 1, three taps).

Top module: `frac_deskew`

## Requirements
- R1: After reset, res_vld is 0 and res_i and res_q are 0. Until the first offset write, the taps are those for s0 = 0.
- R2: Every cycle with smp_vld high gives exactly one result with res_vld high two clock cycles later. res_vld is low at every other time, and res_i and res_q hold their values between results.
- R3: The result for accepted sample n is the sum over i = -l..l of c_i * x[n-l+i]. Sample indices count accepted samples only, so cycles without smp_vld do not shift the window. Samples before the first one after reset count as 0.
- R4: Each tap c_i equals the product over j != i (j in -l..l) of (s0 - j)/(i - j). Each output is within 2 LSB of the exactly weighted, rounded sum.
- R5: With s0 = 0 the output is exactly the input delayed by l accepted samples.
- R6: ofs_val is signed two's complement with 15 fractional bits (s0 = ofs_val/32768), valid from -16384 to +16384 (±0.5). At ±16384 all taps are exact, so outputs are exact.
- R7: An offset is taken in the cycle ofs_wr is high. Samples accepted in the first 2l+1 cycles after that cycle use the previous taps; samples accepted later use the new ones. All taps switch together, and the sample window is kept across the switch.
- R8: I and Q are filtered with the same taps.
- R9: Each output is rounded half toward +infinity (x.5 goes up) and saturated to the signed range of DW bits (-32768..32767 by default).
- R10: A write while the taps are still being computed restarts the computation. The last write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Input sample valid |
| smp_i | input | DW | In-phase input sample, signed |
| smp_q | input | DW | Quadrature input sample, signed |
| ofs_wr | input | 1 | Load strobe for the fractional offset |
| ofs_val | input | SW | Fractional offset s0, signed, SF fractional bits |
| res_vld | output | 1 | Result valid |
| res_i | output | DW | Deskewed in-phase result |
| res_q | output | DW | Deskewed quadrature result |

## Verification
A single impulse and a ramp under the reset taps separate a correct pure delay from an off-by-one window or a wrong tap order. At offsets of ±0.5, small values such as -4 and 3 land exactly on half-LSB results, which exposes rounding toward the wrong side. Full-scale steps of opposite sign drive both saturation limits. Pseudo-random, different I and Q data at a general offset checks the computed weights on both rails. Samples sent right after a write, gaps in the valid stream, and two back-to-back writes fix the cycle of the tap swap, show that the window advances only on accepted samples, and confirm that the last write wins.

// File: rtl/frac_deskew_pkg.sv
package frac_deskew_pkg;

  // Product of (i - j) over j != i, j in -half..half, for tap index t = i + half
  function automatic longint lag_den(input int half, input int t);
    longint d;
    int     i;
    d = 1;
    i = t - half;
    for (int j = -half; j <= half; j++) begin
      if (j != i) d = d * longint'(i - j);
    end
    return d;
  endfunction

  // Reciprocal of the denominator in fixed point with frac fractional bits, rounded
  function automatic longint lag_recip(input int half, input int t, input int frac);
    longint d;
    longint a;
    longint q;
    d = lag_den(half, t);
    a = (d < 0) ? -d : d;
    q = (((longint'(1) <<< (frac + 1)) / a) + 1) >>> 1;
    return (d < 0) ? -q : q;
  endfunction

endpackage

// File: rtl/frac_deskew_coef.sv
module frac_deskew_coef #(
  parameter int HALF = 1,
  parameter int SW   = 16,
  parameter int SF   = 15,
  parameter int CF   = 20,
  parameter int CW   = 25
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [SW-1:0]               val,
  output logic [2*HALF:0][CW-1:0]     coef
);
  import frac_deskew_pkg::*;

  localparam int NTAP = 2 * HALF + 1;
  localparam int STW  = $clog2(NTAP + 1);
  localparam logic signed [CW-1:0]   ONE = {{(CW-CF-1){1'b0}}, 1'b1, {CF{1'b0}}};
  localparam logic signed [2*CW-1:0] RND = {{(2*CW-CF){1'b0}}, 1'b1, {(CF-1){1'b0}}};

  function automatic logic [NTAP-1:0][CW-1:0] recip_table();
    logic [NTAP-1:0][CW-1:0] r;
    for (int t = 0; t < NTAP; t++) r[t] = CW'(lag_recip(HALF, t, CF));
    return r;
  endfunction

  localparam logic [NTAP-1:0][CW-1:0] RECIP = recip_table();

  // Fixed-point multiply with CF fractional bits, rounded half up
  function automatic logic [CW-1:0] mulr(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic signed [2*CW-1:0] p;
    p = (2*CW)'($signed(a)) * (2*CW)'($signed(b));
    p = p + RND;
    return p[CF+CW-1:CF];
  endfunction

  logic                      run_q, run_n;
  logic [STW-1:0]            step_q, step_n;
  logic [SW-1:0]             s0_q, s0_n;
  logic [NTAP-1:0][CW-1:0]   acc_q, acc_n;
  logic [NTAP-1:0][CW-1:0]   coef_q, coef_n;
  logic signed [CW-1:0]      s_ext, j_term, fac;
  logic                      en;
  int                        jv;

  assign en = wr | run_q;

  always_comb begin
    s_ext  = CW'($signed(s0_q)) <<< (CF - SF);
    jv     = int'(step_q) - HALF;
    j_term = CW'(jv) <<< CF;
    fac    = s_ext - j_term;

    run_n  = run_q;
    step_n = step_q;
    s0_n   = s0_q;
    acc_n  = acc_q;
    coef_n = coef_q;
    if (wr) begin
      run_n  = 1'b1;
      step_n = '0;
      s0_n   = val;
      for (int t = 0; t < NTAP; t++) acc_n[t] = ONE;
    end else if (run_q) begin
      if (step_q != STW'(NTAP)) begin
        for (int t = 0; t < NTAP; t++) begin
          if (STW'(t) != step_q) acc_n[t] = mulr(acc_q[t], fac);
        end
        step_n = step_q + 1'b1;
      end else begin
        for (int t = 0; t < NTAP; t++) coef_n[t] = mulr(acc_q[t], RECIP[t]);
        run_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
      s0_q   <= '0;
      acc_q  <= '0;
      for (int t = 0; t < NTAP; t++) coef_q[t] <= (t == HALF) ? ONE : '0;
    end else if (en) begin
      run_q  <= run_n;
      step_q <= step_n;
      s0_q   <= s0_n;
      acc_q  <= acc_n;
      coef_q <= coef_n;
    end
  end

  assign coef = coef_q;

endmodule

// File: rtl/frac_deskew_win.sv
module frac_deskew_win #(
  parameter int DW   = 16,
  parameter int NTAP = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [DW-1:0]             din,
  output logic [NTAP-1:0][DW-1:0]   win
);
  logic [NTAP-1:0][DW-1:0] win_q, win_n;

  always_comb begin
    win_n = win_q;
    for (int k = NTAP - 1; k > 0; k--) win_n[k] = win_q[k-1];
    win_n[0] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    win_q <= '0;
    else if (push) win_q <= win_n;
  end

  assign win = win_q;

endmodule

// File: rtl/frac_deskew_mac.sv
module frac_deskew_mac #(
  parameter int DW   = 16,
  parameter int CW   = 25,
  parameter int CF   = 20,
  parameter int NTAP = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [NTAP-1:0][DW-1:0]   win,
  input  logic [NTAP-1:0][CW-1:0]   coef,
  output logic [DW-1:0]             y
);
  localparam int SUMW = DW + CW + $clog2(NTAP) + 1;
  localparam logic signed [SUMW-1:0] RND  = {{(SUMW-CF){1'b0}}, 1'b1, {(CF-1){1'b0}}};
  localparam logic signed [SUMW-1:0] MAXV = SUMW'((longint'(1) <<< (DW - 1)) - 1);
  localparam logic signed [SUMW-1:0] MINV = -SUMW'(longint'(1) <<< (DW - 1));

  logic signed [SUMW-1:0] sum, rnd;
  logic [DW-1:0]          y_q, y_n;

  always_comb begin
    sum = '0;
    // newest sample sits in win[0]; tap t pairs with win[NTAP-1-t]
    for (int t = 0; t < NTAP; t++) begin
      sum = sum + SUMW'($signed(coef[t])) * SUMW'($signed(win[NTAP-1-t]));
    end
    rnd = (sum + RND) >>> CF;
    if (rnd > MAXV)      y_n = MAXV[DW-1:0];
    else if (rnd < MINV) y_n = MINV[DW-1:0];
    else                 y_n = rnd[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  y_q <= '0;
    else if (en) y_q <= y_n;
  end

  assign y = y_q;

endmodule

// File: rtl/frac_deskew.sv
module frac_deskew #(
  parameter int HALF = 1,
  parameter int DW   = 16,
  parameter int SW   = 16,
  parameter int SF   = 15,
  parameter int CF   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] smp_q,
  input  logic          ofs_wr,
  input  logic [SW-1:0] ofs_val,
  output logic          res_vld,
  output logic [DW-1:0] res_i,
  output logic [DW-1:0] res_q
);
  localparam int NTAP = 2 * HALF + 1;
  localparam int IB   = 2 + 3 * HALF;
  localparam int CW   = CF + IB;

  logic [1:0]                rsync_q;
  logic                      rst_core_n;
  logic                      win_vld_q, win_vld_n;
  logic                      out_vld_q, out_vld_n;
  logic [NTAP-1:0][CW-1:0]   coef_bank;
  logic [1:0][DW-1:0]        din;
  logic [1:0][DW-1:0]        dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  frac_deskew_coef #(
    .HALF(HALF), .SW(SW), .SF(SF), .CF(CF), .CW(CW)
  ) u_coef (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr    (ofs_wr),
    .val   (ofs_val),
    .coef  (coef_bank)
  );

  assign din[0] = smp_i;
  assign din[1] = smp_q;

  for (genvar r = 0; r < 2; r++) begin : g_rail
    logic [NTAP-1:0][DW-1:0] win;

    frac_deskew_win #(.DW(DW), .NTAP(NTAP)) u_win (
      .clk   (clk),
      .rst_n (rst_core_n),
      .push  (smp_vld),
      .din   (din[r]),
      .win   (win)
    );

    frac_deskew_mac #(.DW(DW), .CW(CW), .CF(CF), .NTAP(NTAP)) u_mac (
      .clk   (clk),
      .rst_n (rst_core_n),
      .en    (win_vld_q),
      .win   (win),
      .coef  (coef_bank),
      .y     (dout[r])
    );
  end

  always_comb begin
    win_vld_n = smp_vld;
    out_vld_n = win_vld_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      win_vld_q <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      win_vld_q <= win_vld_n;
      out_vld_q <= out_vld_n;
    end
  end

  assign res_vld = out_vld_q;
  assign res_i   = dout[0];
  assign res_q   = dout[1];

endmodule

// File: rtl/frac_deskew_chk.sv
module frac_deskew_chk #(
  parameter int NTAP = 3,
  parameter int DW   = 16,
  parameter int CW   = 25
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      smp_vld,
  input logic                      ofs_wr,
  input logic                      res_vld,
  input logic [DW-1:0]             res_i,
  input logic [DW-1:0]             res_q,
  input logic [NTAP-1:0][CW-1:0]   coef
);
  logic       armed_q;
  logic [7:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      since_q <= '0;
    end else if (ofs_wr) begin
      armed_q <= 1'b1;
      since_q <= '0;
    end else if (armed_q && since_q != 8'hff) begin
      since_q <= since_q + 8'd1;
    end
  end

  // R2: each accepted sample yields a result two cycles later
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> ##1 res_vld);

  // R2: no result without an accepted sample
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ##1 !res_vld);

  // R2: outputs hold between results
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> ($stable(res_i) && $stable(res_q)));

  // R7: active taps change only NTAP+1 cycles after the last offset write
  a_r7_swap_time: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(coef) |-> (armed_q && since_q == 8'(NTAP + 1)));

endmodule

bind frac_deskew frac_deskew_chk #(.NTAP(NTAP), .DW(DW), .CW(CW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .smp_vld (smp_vld),
  .ofs_wr  (ofs_wr),
  .res_vld (res_vld),
  .res_i   (res_i),
  .res_q   (res_q),
  .coef    (coef_bank)
);

// File: tb/frac_deskew_tb_top.sv
module frac_deskew_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 1;
  localparam int NTAP = 2 * HALF + 1;
  localparam int DW   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_vld = 1'b0;
  logic [DW-1:0] smp_i = '0;
  logic [DW-1:0] smp_q = '0;
  logic          ofs_wr = 1'b0;
  logic [15:0]   ofs_val = '0;
  logic          res_vld;
  logic [DW-1:0] res_i;
  logic [DW-1:0] res_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_deskew dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
    .ofs_wr(ofs_wr), .ofs_val(ofs_val), .res_vld(res_vld), .res_i(res_i), .res_q(res_q)
  );

  typedef struct { int ei; int eq; int tol; string req; } exp_t;
  exp_t sb[$];

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  real cur[NTAP];
  real pend[NTAP];
  bit  cur_exact, pend_exact, pend_on;
  int  since;
  int  hi[NTAP];
  int  hq[NTAP];
  int  seed = 12345;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic real lag_tap(input real s, input int t);
    real p;
    int  i;
    p = 1.0;
    i = t - HALF;
    for (int j = -HALF; j <= HALF; j++) if (j != i) p = p * (s - j) / (i - j);
    return p;
  endfunction

  function automatic int rnd_sat(input real a);
    real f;
    f = $floor(a + 0.5);
    if (f > 32767.0)  return 32767;
    if (f < -32768.0) return -32768;
    return $rtoi(f);
  endfunction

  function automatic int lcg();
    seed = seed * 1664525 + 1013904223;
    return (seed >>> 12) % 32768;
  endfunction

  task automatic cyc_begin();
    @(negedge clk);
    smp_vld = 1'b0;
    ofs_wr  = 1'b0;
    since++;
    if (pend_on && since >= NTAP + 1) begin
      cur = pend;
      cur_exact = pend_exact;
      pend_on = 1'b0;
    end
  endtask

  task automatic wr_ofs(input int v);
    cyc_begin();
    ofs_wr  = 1'b1;
    ofs_val = 16'(v);
    since   = 0;
    for (int t = 0; t < NTAP; t++) pend[t] = lag_tap(v / 32768.0, t);
    pend_exact = (v == 0 || v == 16384 || v == -16384);
    pend_on = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc_begin();
  endtask

  task automatic send(input int xi, input int xq, input string req);
    exp_t e;
    real  ai, aq;
    cyc_begin();
    smp_vld = 1'b1;
    smp_i   = DW'(xi);
    smp_q   = DW'(xq);
    for (int k = NTAP - 1; k > 0; k--) begin
      hi[k] = hi[k-1];
      hq[k] = hq[k-1];
    end
    hi[0] = xi;
    hq[0] = xq;
    ai = 0.0;
    aq = 0.0;
    for (int t = 0; t < NTAP; t++) begin
      ai = ai + cur[t] * hi[NTAP-1-t];
      aq = aq + cur[t] * hq[NTAP-1-t];
    end
    e.ei  = rnd_sat(ai);
    e.eq  = rnd_sat(aq);
    e.tol = cur_exact ? 0 : 2;
    e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: pops one expected item per result
  always @(negedge clk) begin
    exp_t e;
    int   ai, aq;
    if (rst_n && res_vld) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected result", 1, 0);
      end else begin
        e  = sb.pop_front();
        ai = $signed(res_i);
        aq = $signed(res_q);
        check((ai - e.ei <= e.tol) && (e.ei - ai <= e.tol), e.req, "res_i", ai, e.ei);
        check((aq - e.eq <= e.tol) && (e.eq - aq <= e.tol), e.req, "res_q", aq, e.eq);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int t = 0; t < NTAP; t++) begin
      cur[t] = (t == HALF) ? 1.0 : 0.0;
      hi[t] = 0;
      hq[t] = 0;
    end
    cur_exact = 1'b1;
    pend_on = 1'b0;
    since = 100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(res_vld == 1'b0, "R1", "res_vld after reset", int'(res_vld), 0);
    check(res_i == '0, "R1", "res_i after reset", $signed(res_i), 0);
    check(res_q == '0, "R1", "res_q after reset", $signed(res_q), 0);

    // R1: reset taps give a pure delay: impulse and ramp
    send(1000, -700, "R1");
    send(0, 0, "R1");
    send(0, 0, "R1");
    for (int k = 0; k < 5; k++) send(k * 37 - 60, 90 - k * 11, "R1");

    // R7: samples right after a write still use previous taps
    wr_ofs(16384);
    send(200, -300, "R7");
    send(-400, 500, "R7");
    send(600, -700, "R7");
    // R9: new taps (exact at +0.5), half-LSB rounding cases
    send(0, 0, "R9");
    send(0, 0, "R9");
    send(-4, 3, "R9");
    send(0, 0, "R9");
    send(0, 0, "R9");
    send(3, -4, "R9");
    send(0, 0, "R9");
    send(0, 0, "R9");
    // R9: saturation at both limits
    send(-32768, 32767, "R9");
    send(32767, -32768, "R9");
    send(32767, -32768, "R9");
    send(32767, -32768, "R9");
    send(-32768, 32767, "R9");
    send(-32768, 32767, "R9");

    // R6: negative range extreme, exact taps
    wr_ofs(-16384);
    idle(6);
    for (int k = 0; k < 8; k++) send(lcg(), lcg(), "R6");

    // R4 and R8: general offset, distinct I and Q data
    wr_ofs(5000);
    idle(6);
    for (int k = 0; k < 6; k++) send(lcg(), lcg(), "R4");
    for (int k = 0; k < 6; k++) send(lcg() / 2, -lcg() / 3, "R8");

    // R3: gaps in the valid stream do not shift the window
    send(1500, -2500, "R3");
    idle(2);
    send(-800, 400, "R3");
    idle(3);
    send(2200, 100, "R3");
    idle(1);
    send(-50, -3000, "R3");

    // R10: back-to-back writes, last one wins
    wr_ofs(7000);
    wr_ofs(-9000);
    idle(6);
    for (int k = 0; k < 6; k++) send(lcg(), lcg(), "R10");

    // R5: offset zero restores an exact delay
    wr_ofs(0);
    idle(6);
    for (int k = 0; k < 6; k++) send(lcg(), lcg(), "R5");

    idle(6);
    check(sb.size() == 0, "R2", "results still missing", sb.size(), 0);
    finish_run();
  end

endmodule